// File: doc/BRIEF.md
# Lane Drive Adjustment Encoder

This block turns the drive adjustment requests that a link sink reports for each lane into the lane configuration bytes that the source writes back during link training. It takes two packed request bytes (one 4-bit request per lane: a voltage swing level and a pre-emphasis level), one byte of post-cursor2 requests (2 bits per lane) and the number of active lanes. It produces one lane-set byte per lane, two packed post-cursor2 set bytes, and clamped 2-bit swing, pre-emphasis and post-cursor codes per lane that an analog driver lookup can consume.

Clamping follows the link's level budget. Pre-emphasis and post-cursor2 saturate at level 3. The swing ceiling is 3 minus the requested pre-emphasis, so a stronger pre-emphasis leaves less room for swing. Every field that saturates raises its own "maximum reached" flag at a fixed bit of the output byte. The encoding is combinational. A start pulse loads the result into an output register and raises a one-cycle valid strobe. The outputs then hold until the next start.

Top module: `lane_drive_encoder`

## Requirements
- R1: Lane i (0..3) takes its request from `adj_req[4i+3:4i]`, which is byte i/2, low nibble for even lanes and high nibble for odd lanes. Within the nibble, bits [1:0] are the requested swing and bits [3:2] are the requested pre-emphasis.
- R2: Lane-set byte i sits at `lane_set[8i+7:8i]`. Bits [1:0] hold swing, bit 2 is the swing-maximum flag, bits [4:3] hold pre-emphasis, bit 5 is the pre-emphasis-maximum flag, and bits [7:6] are zero.
- R3: A requested pre-emphasis of 3 yields pre-emphasis 3 with its flag set and swing 0 with no swing flag, giving lane byte 0x38.
- R4: When pre-emphasis is below 3 and the requested swing is at or above 3 minus pre-emphasis, swing is set to 3 minus pre-emphasis and the swing flag is set (for example, nibble 0x6 gives 0x0E and nibble 0x9 gives 0x15).
- R5: When neither limit is reached, swing and pre-emphasis pass through unchanged and both flags are clear.
- R6: The post-cursor2 request of lane i is `pc_req[2i+1:2i]`. Its setting occupies `pc_set[4i+3:4i]` (byte i/2, low nibble for even lanes): bits [1:0] hold the level and bit 2 is the maximum flag. A request of 3 gives 0x7; lower values pass unchanged.
- R7: `sw_code`, `pe_code` and `pc_code` hold the clamped 2-bit levels of lane i at bits [2i+1:2i], without flags. In every lane, swing plus pre-emphasis never exceeds 3.
- R8: Lanes whose index is greater than or equal to `lane_cnt` output zero in `lane_set`, `pc_set` and all three code outputs.
- R9: The outputs update on the clock edge that samples `start` high, and `valid` is high for exactly the following cycle. Without `start`, all outputs hold their values and `valid` is low.
- R10: After synchronous reset, all outputs and `valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe for a new encoding |
| adj_req | input | 16 | Packed per-lane swing/pre-emphasis requests |
| pc_req | input | 8 | Packed per-lane post-cursor2 requests |
| lane_cnt | input | 3 | Number of active lanes (1, 2 or 4) |
| valid | output | 1 | High for one cycle after a load |
| lane_set | output | 32 | Four lane-set bytes |
| pc_set | output | 16 | Two packed post-cursor2 set bytes |
| sw_code | output | 8 | Clamped swing level per lane |
| pe_code | output | 8 | Clamped pre-emphasis level per lane |
| pc_code | output | 8 | Clamped post-cursor2 level per lane |

## Verification
The only internal state is the output register and the valid flag. A wrong value in the register shows at the ports in the cycle after the start pulse that loaded it, as a lane byte or code that disagrees with the clamping rules. A hold fault shows as outputs that drift between start pulses. A lane-mask or nibble-select error appears on the first load that uses a reduced lane count or distinct per-lane requests. For that reason, the vectors give every lane a different request and repeat the same stimulus at lane counts of 4, 2 and 1.

// File: rtl/lde_pkg.sv
package lde_pkg;

    localparam logic [1:0] LEVEL_TOP = 2'd3;

    typedef struct packed {
        logic [1:0] pre;
        logic [1:0] swing;
    } lane_req_t;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       pre_max;
        logic [1:0] pre;
        logic       sw_max;
        logic [1:0] swing;
    } lane_set_t;

    typedef struct packed {
        logic       pc_max;
        logic [1:0] pc;
    } pc_set_t;

    function automatic lane_set_t encode_lane(input lane_req_t r);
        lane_set_t  o;
        logic [1:0] sw_ceil;
        o       = '0;
        sw_ceil = LEVEL_TOP - r.pre;
        if (r.pre >= LEVEL_TOP) begin
            o.pre     = LEVEL_TOP;
            o.pre_max = 1'b1;
            o.swing   = 2'd0;
        end else if (r.swing >= sw_ceil) begin
            o.pre    = r.pre;
            o.swing  = sw_ceil;
            o.sw_max = 1'b1;
        end else begin
            o.pre   = r.pre;
            o.swing = r.swing;
        end
        return o;
    endfunction

    function automatic pc_set_t encode_pc(input logic [1:0] req);
        pc_set_t o;
        o = '0;
        if (req >= LEVEL_TOP) begin
            o.pc     = LEVEL_TOP;
            o.pc_max = 1'b1;
        end else begin
            o.pc = req;
        end
        return o;
    endfunction

endpackage

// File: rtl/lde_lane.sv
module lde_lane
    import lde_pkg::*;
(
    input  logic [3:0] req_nib,
    input  logic [1:0] pc_req,
    input  logic       active,
    output logic [7:0] set_byte,
    output logic [3:0] pc_nib,
    output logic [1:0] sw_lvl,
    output logic [1:0] pe_lvl,
    output logic [1:0] pc_lvl
);
    lane_set_t ls;
    pc_set_t   ps;

    always_comb begin
        ls = encode_lane(lane_req_t'(req_nib));
        ps = encode_pc(pc_req);
        if (!active) begin
            ls = '0;
            ps = '0;
        end
        set_byte = ls;
        pc_nib   = {1'b0, ps};
        sw_lvl   = ls.swing;
        pe_lvl   = ls.pre;
        pc_lvl   = ps.pc;
    end
endmodule

// File: rtl/lde_hold.sv
module lde_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) q <= d;
        end
    end
endmodule

// File: rtl/lane_drive_encoder.sv
module lane_drive_encoder #(
    parameter int LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [LANES*4-1:0]           adj_req,
    input  logic [LANES*2-1:0]           pc_req,
    input  logic [$clog2(LANES+1)-1:0]   lane_cnt,
    output logic                         valid,
    output logic [LANES*8-1:0]           lane_set,
    output logic [LANES*4-1:0]           pc_set,
    output logic [LANES*2-1:0]           sw_code,
    output logic [LANES*2-1:0]           pe_code,
    output logic [LANES*2-1:0]           pc_code
);
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int SET_W  = LANES * 8;
    localparam int PCS_W  = LANES * 4;
    localparam int CODE_W = LANES * 2;
    localparam int WORD_W = SET_W + PCS_W + 3 * CODE_W;

    logic [SET_W-1:0]  nx_set;
    logic [PCS_W-1:0]  nx_pcs;
    logic [CODE_W-1:0] nx_sw, nx_pe, nx_pc;
    logic [WORD_W-1:0] nx_word, held;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic act;
        assign act = (lane_cnt > CNT_W'(i));
        lde_lane u_lane (
            .req_nib  (adj_req[i*4 +: 4]),
            .pc_req   (pc_req[i*2 +: 2]),
            .active   (act),
            .set_byte (nx_set[i*8 +: 8]),
            .pc_nib   (nx_pcs[i*4 +: 4]),
            .sw_lvl   (nx_sw[i*2 +: 2]),
            .pe_lvl   (nx_pe[i*2 +: 2]),
            .pc_lvl   (nx_pc[i*2 +: 2])
        );
    end

    assign nx_word = {nx_set, nx_pcs, nx_sw, nx_pe, nx_pc};

    lde_hold #(.W(WORD_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .d      (nx_word),
        .q      (held),
        .strobe (valid)
    );

    assign {lane_set, pc_set, sw_code, pe_code, pc_code} = held;
endmodule

// File: rtl/lde_checker.sv
module lde_checker #(
    parameter int LANES = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start,
    input logic [$clog2(LANES+1)-1:0] lane_cnt,
    input logic                       valid,
    input logic [LANES*8-1:0]         lane_set,
    input logic [LANES*4-1:0]         pc_set,
    input logic [LANES*2-1:0]         sw_code,
    input logic [LANES*2-1:0]         pe_code
);
    localparam int CNT_W = $clog2(LANES + 1);

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> valid); // R9
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(lane_set) && $stable(pc_set))); // R9

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        AST_LEVEL_BUDGET: assert property (@(posedge clk) disable iff (rst)
            ({1'b0, sw_code[i*2 +: 2]} + {1'b0, pe_code[i*2 +: 2]}) <= 3'd3); // R7
        AST_PRE_TOP_ZERO_SWING: assert property (@(posedge clk) disable iff (rst)
            lane_set[i*8+5] |-> (lane_set[i*8 +: 3] == 3'd0 && lane_set[i*8+3 +: 2] == 2'd3)); // R3
        AST_SWING_FLAG_AT_CEIL: assert property (@(posedge clk) disable iff (rst)
            lane_set[i*8+2] |-> ({1'b0, lane_set[i*8 +: 2]} + {1'b0, lane_set[i*8+3 +: 2]} == 3'd3)); // R4
        AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
            lane_set[i*8+6 +: 2] == 2'b00); // R2
        AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            (start && lane_cnt <= CNT_W'(i)) |=> (lane_set[i*8 +: 8] == 8'h00 && pc_set[i*4 +: 4] == 4'h0)); // R8
    end
endmodule

bind lane_drive_encoder lde_checker #(.LANES(LANES)) i_lde_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lane_cnt (lane_cnt),
    .valid    (valid),
    .lane_set (lane_set),
    .pc_set   (pc_set),
    .sw_code  (sw_code),
    .pe_code  (pe_code)
);

// File: tb/test_lane_drive_encoder.sv
module test_lane_drive_encoder;

    typedef struct packed {
        logic [15:0] adj;
        logic [7:0]  pcr;
        logic [2:0]  cnt;
        logic [31:0] exp_set;
        logic [15:0] exp_pcs;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'h00, 3'd4, 32'h00000000, 16'h0000},
        '{16'h4321, 8'hE4, 3'd4, 32'h08070201, 16'h7210},
        '{16'h8765, 8'hFF, 3'd4, 32'h100E0E09, 16'h7777},
        '{16'hCBA9, 8'h1B, 3'd4, 32'h38151515, 16'h0127},
        '{16'hD0FE, 8'h00, 3'd4, 32'h38003838, 16'h0000},
        '{16'h8765, 8'hFF, 3'd2, 32'h00000E09, 16'h0077},
        '{16'hCBA9, 8'h1B, 3'd1, 32'h00000015, 16'h0007},
        '{16'h3333, 8'h55, 3'd4, 32'h07070707, 16'h1111}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] adj_req = '0;
    logic [7:0]  pc_req = '0;
    logic [2:0]  lane_cnt = '0;
    logic        valid;
    logic [31:0] lane_set;
    logic [15:0] pc_set;
    logic [7:0]  sw_code, pe_code, pc_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lane_drive_encoder i_lane_drive_encoder (
        .clk(clk), .rst(rst), .start(start), .adj_req(adj_req), .pc_req(pc_req),
        .lane_cnt(lane_cnt), .valid(valid), .lane_set(lane_set), .pc_set(pc_set),
        .sw_code(sw_code), .pe_code(pe_code), .pc_code(pc_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [7:0] p, input logic [2:0] c);
        @(negedge clk);
        adj_req  = a;
        pc_req   = p;
        lane_cnt = c;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 lane_set after reset", lane_set, 32'h0);
        check("R10 pc_set/valid after reset", {15'h0, valid, pc_set}, 32'h0);
        check("R10 codes after reset", {8'h0, sw_code, pe_code, pc_code}, 32'h0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R8: vector table
        for (int k = 0; k < NV; k++) begin
            load(VECS[k].adj, VECS[k].pcr, VECS[k].cnt);
            check($sformatf("R1/R2/R3/R4/R5/R8 lane_set vec %0d", k), lane_set, VECS[k].exp_set);
            check($sformatf("R6/R8 pc_set vec %0d", k), {16'h0, pc_set}, {16'h0, VECS[k].exp_pcs});
            check($sformatf("R9 valid vec %0d", k), {31'h0, valid}, 32'h1);
        end

        // R9: valid lasts one cycle; outputs hold while inputs change without start
        @(negedge clk);
        check("R9 valid low after one cycle", {31'h0, valid}, 32'h0);
        adj_req  = 16'hFFFF;
        pc_req   = 8'hFF;
        lane_cnt = 3'd1;
        repeat (4) @(negedge clk);
        check("R9 lane_set held", lane_set, 32'h07070707);
        check("R9 pc_set held", {16'h0, pc_set}, 32'h00001111);
        check("R9 valid stays low", {31'h0, valid}, 32'h0);

        // R7: clamped codes, all lanes active
        load(16'hCBA9, 8'h1B, 3'd4);
        check("R7 sw_code", {24'h0, sw_code}, 32'h15);
        check("R7 pe_code", {24'h0, pe_code}, 32'hEA);
        check("R7 pc_code", {24'h0, pc_code}, 32'h1B);

        // R7 R8: codes masked with one active lane
        load(16'hCBA9, 8'h1B, 3'd1);
        check("R8 codes one lane", {8'h0, sw_code, pe_code, pc_code}, {8'h0, 8'h01, 8'h02, 8'h03});

        // R8: lane count zero clears everything
        load(16'h1234, 8'hAA, 3'd0);
        check("R8 zero lanes lane_set", lane_set, 32'h0);
        check("R8 zero lanes pc/codes", {pc_set, sw_code, pe_code}, 32'h0);

        // R3 R4: every lane at pe=2 sw=3 then pe=3 sw=0
        load(16'hBBBB, 8'h00, 3'd4);
        check("R4 pe2 sw3 all lanes", lane_set, 32'h15151515);
        load(16'hCCCC, 8'h00, 3'd4);
        check("R3 pe3 all lanes", lane_set, 32'h38383838);

        // R10: reset during operation clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid-run reset", lane_set, 32'h0);
        rst = 1'b0;

        finish_run();
    end
endmodule